// File: doc/BRIEF.md
# Self-Clearing Command Handshake Controller

This block sits behind a software command bit that starts a hardware task. A write of 1 to the bit appears as a command request; the block raises a task-go output for the worker logic, holds it until the worker reports completion, and then clears the pending status itself. Software never has to clear the bit, and the worker is never left restarting the task because nobody cleared it.

The default variant is a four-state handshake. It will not start a run while a completion signal from the previous run is still high. After a run it also waits for the request to drop before it accepts a new one. One request therefore gives exactly one run, whatever the timing of the two inputs. A parameter selects one of three variants:
- a reduced three-state variant for systems where the request is known to fall before the task finishes;
- a plain set/clear flag, kept for comparison.

Reset is asserted asynchronously and active low. Its release passes through a two-stage synchronizer before the state register leaves idle.

Top module: `cmd_handshake_ctrl`

## Requirements
- R1: While `rst_n` is low, `task_go_o` and `cmd_pending_o` are 0 at once, with no clock edge needed. After `rst_n` rises, the block stays idle for two more rising clock edges.
- R2: When idle, a request with completion low gives `task_go_o`=1 and `cmd_pending_o`=1 after the next rising edge. When idle with the request low, both outputs stay 0.
- R3: While running, `task_go_o` stays 1 for as long as completion is sampled low, whatever the request input does.
- R4: In MODE 0, completion sampled while running drops `task_go_o` on the next edge. `cmd_pending_o` then stays 1 until the request is sampled low, and falls on the edge that samples it low.
- R5: A request sampled while idle with completion still high gives `cmd_pending_o`=1 and `task_go_o`=0. `task_go_o` rises only on the edge after completion is first sampled low, so a run never starts on a stale completion.
- R6: In MODE 0, a request held high for any number of cycles produces exactly one interval of `task_go_o`. A new interval needs the request to go low and then high again.
- R7: In MODE 1, completion sampled while running returns the block to idle on the next edge, with both outputs 0. The wait for completion to fall (R5) still applies.
- R8: In MODE 2, one flag drives both outputs. Completion clears the flag. A request with completion low sets the flag. When both are high in the same cycle, the flag clears.
- R9: `cmd_pending_o` is 1 in every state except idle. `task_go_o` is 1 only in the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| cmd_set_i | input | 1 | Command request (the software write of 1 to the bit) |
| task_done_i | input | 1 | Completion from the worker logic |
| task_go_o | output | 1 | Task start/run enable to the worker |
| cmd_pending_o | output | 1 | Readable status: the command is pending |

## Verification
Both outputs are decoded from a register, so every response to `cmd_set_i` and `task_done_i` is due on the first rising edge after the inputs are sampled. The bench drives the inputs on the falling edge and checks the outputs on the next falling edge, exactly one edge later. Reset is the exception: assertion clears the outputs at once, so the bench checks them a nanosecond after pulling `rst_n` low. After release, the bench waits three falling edges, which covers the two synchronizer edges, before it drives a request. The number of rising edges of `task_go_o` is counted and compared with the number of requests the stimulus table issues.

// File: rtl/cmd_hs_pkg.sv
package cmd_hs_pkg;
  // Variant selection for the top-level MODE parameter
  localparam int MODE_FULL  = 0;  // four states, waits for request to drop
  localparam int MODE_SHORT = 1;  // three states, no drain state
  localparam int MODE_FLAG  = 2;  // plain set/clear flag

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    HS_IDLE  = 2'b00,
    HS_ARM   = 2'b01,  // request seen, completion still high
    HS_RUN   = 2'b10,  // task running
    HS_DRAIN = 2'b11   // task done, request still high
  } hs_state_e;
endpackage

// File: rtl/cmd_hs_rst_sync.sv
module cmd_hs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/cmd_hs_next.sv
module cmd_hs_next
  import cmd_hs_pkg::*;
#(
  parameter bit DRAIN_EN = 1'b1
) (
  input  hs_state_e st_q,
  input  logic      set_i,
  input  logic      done_i,
  output hs_state_e st_d
);
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_IDLE: begin
        if (set_i) st_d = done_i ? HS_ARM : HS_RUN;
      end
      HS_ARM: begin
        if (!done_i) st_d = HS_RUN;
      end
      HS_RUN: begin
        if (done_i) st_d = DRAIN_EN ? HS_DRAIN : HS_IDLE;
      end
      HS_DRAIN: begin
        if (!set_i) st_d = HS_IDLE;
      end
      default: st_d = HS_IDLE;
    endcase
  end
endmodule

// File: rtl/cmd_hs_state_reg.sv
module cmd_hs_state_reg
  import cmd_hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  hs_state_e st_d,
  output hs_state_e st_q
);
  logic ld_en;

  assign ld_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= HS_IDLE;
    else if (ld_en) st_q <= st_d;
  end
endmodule

// File: rtl/cmd_hs_decode.sv
module cmd_hs_decode
  import cmd_hs_pkg::*;
(
  input  hs_state_e st_q,
  output logic      go_o,
  output logic      pend_o
);
  assign go_o   = (st_q == HS_RUN);
  assign pend_o = (st_q != HS_IDLE);
endmodule

// File: rtl/cmd_hs_flag.sv
module cmd_hs_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic done_i,
  output logic flag_o
);
  logic flag_en;

  assign flag_en = set_i | done_i;

  // completion has priority over the request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_o <= 1'b0;
    else if (flag_en) flag_o <= ~done_i;
  end
endmodule

// File: rtl/cmd_handshake_ctrl.sv
module cmd_handshake_ctrl
  import cmd_hs_pkg::*;
#(
  parameter int MODE = MODE_FULL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_set_i,
  input  logic task_done_i,
  output logic task_go_o,
  output logic cmd_pending_o
);
  localparam bit DRAIN_EN = (MODE == MODE_FULL);

  logic rst_q_n;

  cmd_hs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  generate
    if (MODE == MODE_FLAG) begin : g_flag
      logic flag_q;

      cmd_hs_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_q_n),
        .set_i  (cmd_set_i),
        .done_i (task_done_i),
        .flag_o (flag_q)
      );

      assign task_go_o     = flag_q;
      assign cmd_pending_o = flag_q;
    end else begin : g_fsm
      hs_state_e st_q;
      hs_state_e st_d;

      cmd_hs_next #(.DRAIN_EN(DRAIN_EN)) u_next (
        .st_q   (st_q),
        .set_i  (cmd_set_i),
        .done_i (task_done_i),
        .st_d   (st_d)
      );

      cmd_hs_state_reg u_state (
        .clk   (clk),
        .rst_n (rst_q_n),
        .st_d  (st_d),
        .st_q  (st_q)
      );

      cmd_hs_decode u_dec (
        .st_q   (st_q),
        .go_o   (task_go_o),
        .pend_o (cmd_pending_o)
      );
    end
  endgenerate
endmodule

// File: rtl/cmd_hs_checker.sv
module cmd_hs_checker #(
  parameter int MODE = 0
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_set_i,
  input logic task_done_i,
  input logic task_go_o,
  input logic cmd_pending_o
);
  // R9: the run output never stands without pending status
  p_go_has_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    task_go_o |-> cmd_pending_o);

  generate
    if (MODE != 2) begin : g_fsm_props
      // R2: idle request with completion low starts the task
      p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_pending_o && cmd_set_i && !task_done_i) |=> task_go_o);
      // R2: idle without request stays idle
      p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_pending_o && !cmd_set_i) |=> !cmd_pending_o);
      // R3: running holds while completion is low
      p_run_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (task_go_o && !task_done_i) |=> task_go_o);
      // R5: request under a stale completion waits
      p_stale_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_pending_o && cmd_set_i && task_done_i) |=> (cmd_pending_o && !task_go_o));
      // R5: a run only begins after completion was seen low
      p_start_after_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(task_go_o) |-> $past(!task_done_i));
    end
    if (MODE == 0) begin : g_full_props
      // R4: completion ends the run but keeps pending status
      p_done_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (task_go_o && task_done_i) |=> (cmd_pending_o && !task_go_o));
      // R6: a held request does not restart the task
      p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!task_go_o && cmd_pending_o && $past(task_go_o) && cmd_set_i)
          |=> (!task_go_o && cmd_pending_o));
    end
    if (MODE == 1) begin : g_short_props
      // R7: completion returns straight to idle
      p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (task_go_o && task_done_i) |=> !cmd_pending_o);
    end
    if (MODE == 2) begin : g_flag_props
      // R8: completion clears, also against a request in the same cycle
      p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        task_done_i |=> !cmd_pending_o);
      // R8: request alone sets the flag
      p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_set_i && !task_done_i) |=> (cmd_pending_o && task_go_o));
    end
  endgenerate
endmodule

bind cmd_handshake_ctrl cmd_hs_checker #(.MODE(MODE)) u_hs_checker (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .cmd_set_i     (cmd_set_i),
  .task_done_i   (task_done_i),
  .task_go_o     (task_go_o),
  .cmd_pending_o (cmd_pending_o)
);

// File: tb/test_cmd_handshake_ctrl.sv
module test_cmd_handshake_ctrl;
  logic clk;
  logic rst_n;
  logic cmd_set;
  logic task_done;
  logic go_f, pend_f, go_s, pend_s, go_p, pend_p;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  cmd_handshake_ctrl #(.MODE(0)) i_cmd_handshake_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_set_i(cmd_set), .task_done_i(task_done),
    .task_go_o(go_f), .cmd_pending_o(pend_f));
  cmd_handshake_ctrl #(.MODE(1)) i_cmd_handshake_ctrl_short (
    .clk(clk), .rst_n(rst_n), .cmd_set_i(cmd_set), .task_done_i(task_done),
    .task_go_o(go_s), .cmd_pending_o(pend_s));
  cmd_handshake_ctrl #(.MODE(2)) i_cmd_handshake_ctrl_flag (
    .clk(clk), .rst_n(rst_n), .cmd_set_i(cmd_set), .task_done_i(task_done),
    .task_go_o(go_p), .cmd_pending_o(pend_p));

  // {req[3:0], set, done, full go, full pend, short go, short pend, flag}
  // Each row gives the outputs after the edge that samples that row's inputs.
  localparam int NVEC = 20;
  localparam logic [10:0] VEC [0:NVEC-1] = '{
    {4'd2, 7'b10_11_11_1},  // R2 idle start
    {4'd3, 7'b10_11_11_1},  // R3 run holds
    {4'd4, 7'b11_01_00_0},  // R4 done, request held; R8 clear wins
    {4'd6, 7'b10_01_11_1},  // R6 no restart (short variant restarts)
    {4'd6, 7'b10_01_11_1},  // R6
    {4'd4, 7'b00_00_11_1},  // R4 request low -> idle
    {4'd2, 7'b00_00_11_1},  // R2 idle holds
    {4'd5, 7'b11_01_00_0},  // R5 stale completion
    {4'd5, 7'b01_01_00_0},  // R5 still waiting
    {4'd5, 7'b00_11_00_0},  // R5 start after completion low
    {4'd3, 7'b00_11_00_0},  // R3
    {4'd4, 7'b01_01_00_0},  // R4 done with request low
    {4'd4, 7'b00_00_00_0},  // R4 back to idle
    {4'd6, 7'b10_11_11_1},  // R6 back-to-back request
    {4'd9, 7'b01_01_00_0},  // R9 drain is pending
    {4'd6, 7'b10_01_11_1},  // R6 new request in drain does not start
    {4'd4, 7'b00_00_11_1},  // R4
    {4'd6, 7'b10_11_11_1},  // R6 third request
    {4'd4, 7'b11_01_00_0},  // R4
    {4'd2, 7'b00_00_00_0}   // R2
  };

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s go/pend actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic apply(input logic s, input logic d);
    cmd_set   = s;
    task_done = d;
    @(negedge clk);
  endtask

  task automatic do_reset();
    cmd_set = 1'b0; task_done = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 full", {go_f, pend_f}, 2'b00);
    chk("R1 short", {go_s, pend_s}, 2'b00);
    chk("R1 flag", {go_p, pend_p}, 2'b00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 full after release", {go_f, pend_f}, 2'b00);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int rises = 0;
    logic prev_go;
    rst_n = 1'b0; cmd_set = 1'b0; task_done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 full in reset", {go_f, pend_f}, 2'b00);
    chk("R1 short in reset", {go_s, pend_s}, 2'b00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after sync", {go_f, pend_f}, 2'b00);

    // table walk
    prev_go = go_f;
    for (int i = 0; i < NVEC; i++) begin
      logic [10:0] v;
      string tag;
      v = VEC[i];
      apply(v[6], v[5]);
      tag = $sformatf("R%0d full row %0d", v[10:7], i);
      chk(tag, {go_f, pend_f}, v[4:3]);
      chk($sformatf("R7 short row %0d", i), {go_s, pend_s}, v[2:1]);
      chk($sformatf("R8 flag row %0d", i), {go_p, pend_p}, {v[0], v[0]});
      if (go_f && !prev_go) rises++;
      prev_go = go_f;
    end
    checks++;
    if (rises != 4) begin
      failures++;
      $display("FAIL R6 go intervals actual=%0d expected=4", rises);
    end

    // R1: asynchronous reset in the middle of a run
    apply(1'b1, 1'b0);
    chk("R2 full before reset", {go_f, pend_f}, 2'b11);
    do_reset();

    // R5/R7: stale completion in the short variant
    apply(1'b1, 1'b1);
    chk("R5 short arm", {go_s, pend_s}, 2'b01);
    chk("R5 full arm", {go_f, pend_f}, 2'b01);
    apply(1'b0, 1'b1);
    chk("R5 short still arm", {go_s, pend_s}, 2'b01);
    apply(1'b0, 1'b0);
    chk("R7 short run", {go_s, pend_s}, 2'b11);
    chk("R5 full run", {go_f, pend_f}, 2'b11);
    apply(1'b0, 1'b1);
    chk("R7 short idle after done", {go_s, pend_s}, 2'b00);
    chk("R4 full drain", {go_f, pend_f}, 2'b01);
    apply(1'b0, 1'b0);
    chk("R4 full idle", {go_f, pend_f}, 2'b00);

    // R3: long run with the request toggling
    apply(1'b1, 1'b0);
    for (int k = 0; k < 40; k++) begin
      apply(k[0], 1'b0);
      chk("R3 full long run", {go_f, pend_f}, 2'b11);
      chk("R3 short long run", {go_s, pend_s}, 2'b11);
    end
    apply(1'b0, 1'b1);
    chk("R4 full end of long run", {go_f, pend_f}, 2'b01);
    apply(1'b0, 1'b0);
    chk("R4 full idle after long run", {go_f, pend_f}, 2'b00);

    // R6: request held through a long wait after completion
    apply(1'b1, 1'b0);
    apply(1'b1, 1'b1);
    for (int k = 0; k < 20; k++) begin
      apply(1'b1, k[1]);
      chk("R6 held request no restart", {go_f, pend_f}, 2'b01);
    end
    apply(1'b0, 1'b0);
    chk("R6 idle after release", {go_f, pend_f}, 2'b00);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule